// File: doc/BRIEF.md
# Pipelined Eight-Point Radix-2 FFT Engine

This block transforms one row of eight complex samples at a time, forward or inverse, and returns the eight spectral values in natural order. A row arrives as a single wide word with one 36-bit lane per sample. Each lane holds a signed 18-bit real part in its upper half and a signed 18-bit imaginary part in its lower half. The block is the butterfly core of a larger transform. The wider twiddle pass and the sample storage sit outside it.

The work is split across three registered stages, and each stage has its own four-state controller. The first stage splits the row into its even-indexed and odd-indexed samples and runs a radix-2 four-point transform on each half. The second stage rotates the odd-half results. The 45° and 135° factors go through two general complex multipliers. The quarter-turn factor is applied by swapping and negating parts. The third stage is four two-point butterflies. Every stage hands its row to the next with a valid/ready handshake, so up to three rows can be in flight at once. A mode bit travels with each row and selects conjugated twiddles for the inverse transform. The inverse output is not scaled.

Top module: `fft8_engine`

## Requirements
- R1: With `inverse` low at acceptance, output lane k equals the sum over n of x[n]·e^(−j2πnk/8) to within 1 LSB per part. Lane i occupies `[36i+35:36i+18]` (real) and `[36i+17:36i]` (imaginary) on both buses.
- R2: With `inverse` high at acceptance, output lane k equals the sum over n of x[n]·e^(+j2πnk/8) to within 1 LSB per part, with no division by 8.
- R3: The mode is sampled together with the row when it is accepted. Changing `inverse` later has no effect on that row, and rows of different modes in flight each keep their own mode.
- R4: A row whose odd-indexed lanes are all zero yields exactly the ideal result. The quarter-turn path and the adders do no rounding.
- R5: After reset, `in_ready` is 1, `out_valid` is 0 and every stage state is 00.
- R6: Each stage moves through the states load 00, process 01 and unload 10 in turn, and reports its state on `stage_st`: bits [1:0] for stage 1, [3:2] for stage 2 and [5:4] for stage 3. A stage that accepts a row enters 01 on the next cycle and 10 on the cycle after that.
- R7: While `out_valid` is high and `out_ready` is low, the last stage sits in 11, `out_valid` stays high and `out_data` is held.
- R8: With an empty pipeline, `out_valid` rises five clock edges after the edge that accepts a row.
- R9: With the output free, a new row is accepted every third cycle. With the output blocked, exactly three rows are accepted, after which `in_ready` stays low and all three stages report 11.
- R10: Samples in the range −1024..1023 in every part, including full-scale rows, give correct results with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| inverse | input | 1 | 1 selects conjugated twiddles for the row being accepted |
| in_valid | input | 1 | Input row present |
| in_ready | output | 1 | Stage 1 is loading and takes the row on this edge |
| in_data | input | 288 | Eight complex input lanes |
| out_valid | output | 1 | Result row present |
| out_ready | input | 1 | Consumer takes the result row on this edge |
| out_data | output | 288 | Eight complex output lanes in natural order |
| stage_st | output | 6 | Controller state of the three stages, two bits each |

## Verification
The assertions assume that every accepted row has each real and imaginary part inside the 11-bit signed range. This is the range the guard bits protect, and one property checks it at acceptance. The rest of the properties concern the state sequence and the output hold, and they assume only that the consumer may stall at any time. The stimulus draws every part from −1024..1023 and pushes the two full-scale patterns to the edges of that range. It never goes beyond the range, so no check depends on wrap-around.

// File: rtl/fft8_pkg.sv
package fft8_pkg;
   localparam int NPT = 8;

   typedef enum logic [1:0] {
      ST_LOAD = 2'b00,
      ST_PROC = 2'b01,
      ST_UNLD = 2'b10,
      ST_HALT = 2'b11
   } stage_st_e;
endpackage

// File: rtl/fft8_stage_ctl.sv
module fft8_stage_ctl
   import fft8_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       up_valid,
   output logic       up_ready,
   output logic       dn_valid,
   input  logic       dn_ready,
   output logic       load_en,
   output logic       proc_en,
   output logic [1:0] st
);
   stage_st_e state_q, state_d;

   always_comb begin
      state_d  = state_q;
      up_ready = 1'b0;
      dn_valid = 1'b0;
      load_en  = 1'b0;
      proc_en  = 1'b0;
      unique case (state_q)
         ST_LOAD: begin
            up_ready = 1'b1;
            if (up_valid) begin
               load_en = 1'b1;
               state_d = ST_PROC;
            end
         end
         ST_PROC: begin
            proc_en = 1'b1;
            state_d = ST_UNLD;
         end
         ST_UNLD: begin
            dn_valid = 1'b1;
            state_d  = dn_ready ? ST_LOAD : ST_HALT;
         end
         default: begin
            dn_valid = 1'b1;
            if (dn_ready) state_d = ST_LOAD;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_LOAD;
      else        state_q <= state_d;
   end

   assign st = state_q;
endmodule

// File: rtl/fft8_split4.sv
module fft8_split4
   import fft8_pkg::*;
#(
   parameter int DW = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    up_valid,
   output logic                    up_ready,
   input  logic                    up_inv,
   input  logic [NPT-1:0][DW-1:0]  up_re,
   input  logic [NPT-1:0][DW-1:0]  up_im,
   output logic                    dn_valid,
   input  logic                    dn_ready,
   output logic                    dn_inv,
   output logic [NPT-1:0][DW-1:0]  dn_re,
   output logic [NPT-1:0][DW-1:0]  dn_im,
   output logic [1:0]              st
);
   logic load_en, proc_en, inv_q;
   logic [NPT-1:0][DW-1:0] a_re, a_im, y_re, y_im;

   fft8_stage_ctl u_ctl (
      .clk, .rst_n, .up_valid, .up_ready, .dn_valid, .dn_ready,
      .load_en, .proc_en, .st
   );

   // half 0 takes lanes 0,2,4,6; half 1 takes lanes 1,3,5,7
   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [DW-1:0] b0r, b0i, b1r, b1i, b2r, b2i, b3r, b3i, rr, ri;
      always_comb begin
         b0r = a_re[h] + a_re[h+4];
         b0i = a_im[h] + a_im[h+4];
         b1r = a_re[h] - a_re[h+4];
         b1i = a_im[h] - a_im[h+4];
         b2r = a_re[h+2] + a_re[h+6];
         b2i = a_im[h+2] + a_im[h+6];
         b3r = a_re[h+2] - a_re[h+6];
         b3i = a_im[h+2] - a_im[h+6];
         if (inv_q) begin
            rr = -b3i;
            ri = b3r;
         end else begin
            rr = b3i;
            ri = -b3r;
         end
      end
      assign y_re[4*h+0] = b0r + b2r;
      assign y_im[4*h+0] = b0i + b2i;
      assign y_re[4*h+2] = b0r - b2r;
      assign y_im[4*h+2] = b0i - b2i;
      assign y_re[4*h+1] = b1r + rr;
      assign y_im[4*h+1] = b1i + ri;
      assign y_re[4*h+3] = b1r - rr;
      assign y_im[4*h+3] = b1i - ri;
   end

   always_ff @(posedge clk) begin
      if (load_en) begin
         a_re  <= up_re;
         a_im  <= up_im;
         inv_q <= up_inv;
      end
      if (proc_en) begin
         dn_re <= y_re;
         dn_im <= y_im;
      end
   end

   assign dn_inv = inv_q;
endmodule

// File: rtl/fft8_twiddle.sv
module fft8_twiddle
   import fft8_pkg::*;
#(
   parameter int DW   = 18,
   parameter int FRAC = 17
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    up_valid,
   output logic                    up_ready,
   input  logic                    up_inv,
   input  logic [NPT-1:0][DW-1:0]  up_re,
   input  logic [NPT-1:0][DW-1:0]  up_im,
   output logic                    dn_valid,
   input  logic                    dn_ready,
   output logic [NPT-1:0][DW-1:0]  dn_re,
   output logic [NPT-1:0][DW-1:0]  dn_im,
   output logic [1:0]              st
);
   localparam int EW   = 2 * DW + 1;
   localparam int COEF = int'(0.70710678118654752 * (2.0 ** FRAC));
   localparam logic signed [DW-1:0] CP  = DW'(COEF);
   localparam logic signed [DW-1:0] CN  = DW'(-COEF);
   localparam logic signed [EW-1:0] RND = {{(EW-1){1'b0}}, 1'b1} << (FRAC - 1);

   logic load_en, proc_en, inv_q;
   logic [NPT-1:0][DW-1:0] a_re, a_im, y_re, y_im;

   fft8_stage_ctl u_ctl (
      .clk, .rst_n, .up_valid, .up_ready, .dn_valid, .dn_ready,
      .load_en, .proc_en, .st
   );

   // even-half results and the odd-half DC term need no rotation
   for (genvar i = 0; i < 5; i++) begin : g_pass
      assign y_re[i] = a_re[i];
      assign y_im[i] = a_im[i];
   end

   // quarter turn: -j forward, +j inverse
   assign y_re[6] = inv_q ? -a_im[6] : a_im[6];
   assign y_im[6] = inv_q ? a_re[6] : -a_re[6];

   // general multipliers on lanes 5 (45 degrees) and 7 (135 degrees)
   for (genvar m = 0; m < 2; m++) begin : g_mul
      localparam int L = 5 + 2 * m;
      logic signed [DW-1:0] ar, ai, wr, wi;
      logic signed [EW-1:0] pr, pi;
      assign ar = a_re[L];
      assign ai = a_im[L];
      assign wr = (m == 0) ? CP : CN;
      assign wi = inv_q ? CP : CN;
      assign pr = EW'(ar) * EW'(wr) - EW'(ai) * EW'(wi) + RND;
      assign pi = EW'(ar) * EW'(wi) + EW'(ai) * EW'(wr) + RND;
      assign y_re[L] = DW'(pr >>> FRAC);
      assign y_im[L] = DW'(pi >>> FRAC);
   end

   always_ff @(posedge clk) begin
      if (load_en) begin
         a_re  <= up_re;
         a_im  <= up_im;
         inv_q <= up_inv;
      end
      if (proc_en) begin
         dn_re <= y_re;
         dn_im <= y_im;
      end
   end
endmodule

// File: rtl/fft8_merge2.sv
module fft8_merge2
   import fft8_pkg::*;
#(
   parameter int DW = 18
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    up_valid,
   output logic                    up_ready,
   input  logic [NPT-1:0][DW-1:0]  up_re,
   input  logic [NPT-1:0][DW-1:0]  up_im,
   output logic                    dn_valid,
   input  logic                    dn_ready,
   output logic [NPT-1:0][DW-1:0]  dn_re,
   output logic [NPT-1:0][DW-1:0]  dn_im,
   output logic [1:0]              st
);
   localparam int HALF = NPT / 2;

   logic load_en, proc_en;
   logic [NPT-1:0][DW-1:0] a_re, a_im, y_re, y_im;

   fft8_stage_ctl u_ctl (
      .clk, .rst_n, .up_valid, .up_ready, .dn_valid, .dn_ready,
      .load_en, .proc_en, .st
   );

   for (genvar k = 0; k < HALF; k++) begin : g_bfly
      assign y_re[k]      = a_re[k] + a_re[k+HALF];
      assign y_im[k]      = a_im[k] + a_im[k+HALF];
      assign y_re[k+HALF] = a_re[k] - a_re[k+HALF];
      assign y_im[k+HALF] = a_im[k] - a_im[k+HALF];
   end

   always_ff @(posedge clk) begin
      if (load_en) begin
         a_re <= up_re;
         a_im <= up_im;
      end
      if (proc_en) begin
         dn_re <= y_re;
         dn_im <= y_im;
      end
   end
endmodule

// File: rtl/fft8_engine.sv
module fft8_engine
   import fft8_pkg::*;
#(
   parameter int DATA_W  = 18,
   parameter int TW_FRAC = 17
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        inverse,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic [NPT*2*DATA_W-1:0]     in_data,
   output logic                        out_valid,
   input  logic                        out_ready,
   output logic [NPT*2*DATA_W-1:0]     out_data,
   output logic [5:0]                  stage_st
);
   localparam int LW = 2 * DATA_W;

   if (DATA_W < 12 || DATA_W > 32) begin : g_bad_width
      $error("fft8_engine: DATA_W must lie in 12..32");
   end
   if (TW_FRAC < 8 || TW_FRAC > DATA_W - 1) begin : g_bad_frac
      $error("fft8_engine: TW_FRAC must lie in 8..DATA_W-1");
   end

   logic [NPT-1:0][DATA_W-1:0] x_re, x_im, p_re, p_im, q_re, q_im, z_re, z_im;
   logic v1, r1, v2, r2, inv1;
   logic [1:0] st1, st2, st3;

   for (genvar i = 0; i < NPT; i++) begin : g_lane
      assign x_re[i] = in_data[i*LW+DATA_W +: DATA_W];
      assign x_im[i] = in_data[i*LW +: DATA_W];
      assign out_data[i*LW+DATA_W +: DATA_W] = z_re[i];
      assign out_data[i*LW +: DATA_W]        = z_im[i];
   end

   fft8_split4 #(.DW(DATA_W)) u_s1 (
      .clk, .rst_n,
      .up_valid(in_valid), .up_ready(in_ready), .up_inv(inverse),
      .up_re(x_re), .up_im(x_im),
      .dn_valid(v1), .dn_ready(r1), .dn_inv(inv1),
      .dn_re(p_re), .dn_im(p_im), .st(st1)
   );

   fft8_twiddle #(.DW(DATA_W), .FRAC(TW_FRAC)) u_s2 (
      .clk, .rst_n,
      .up_valid(v1), .up_ready(r1), .up_inv(inv1),
      .up_re(p_re), .up_im(p_im),
      .dn_valid(v2), .dn_ready(r2),
      .dn_re(q_re), .dn_im(q_im), .st(st2)
   );

   fft8_merge2 #(.DW(DATA_W)) u_s3 (
      .clk, .rst_n,
      .up_valid(v2), .up_ready(r2),
      .up_re(q_re), .up_im(q_im),
      .dn_valid(out_valid), .dn_ready(out_ready),
      .dn_re(z_re), .dn_im(z_im), .st(st3)
   );

   assign stage_st = {st3, st2, st1};
endmodule

// File: rtl/fft8_engine_chk.sv
module fft8_engine_chk #(
   parameter int DW      = 18,
   parameter int IN_BITS = 11
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic [8*2*DW-1:0]   in_data,
   input logic                out_valid,
   input logic                out_ready,
   input logic [8*2*DW-1:0]   out_data,
   input logic [5:0]          stage_st
);
   function automatic logic parts_in_range(input logic [8*2*DW-1:0] d);
      logic ok;
      ok = 1'b1;
      for (int p = 0; p < 16; p++) begin
         if (!(&d[p*DW+IN_BITS-1 +: DW-IN_BITS+1]) && (|d[p*DW+IN_BITS-1 +: DW-IN_BITS+1]))
            ok = 1'b0;
      end
      return ok;
   endfunction

   // R10: accepted samples stay within the guarded range
   a_r10_input_range: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |-> parts_in_range(in_data));

   // R5: reset leaves every stage loading and no output pending
   a_r5_reset_state: assert property (@(posedge clk)
      !rst_n |=> stage_st == 6'b000000 && !out_valid);

   // R6: acceptance moves stage 1 to processing
   a_r6_accept_to_proc: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> stage_st[1:0] == 2'b01);

   // R6: processing lasts one cycle, then unloading
   a_r6_proc_to_unld: assert property (@(posedge clk) disable iff (!rst_n)
      stage_st[3:2] == 2'b01 |=> stage_st[3:2] == 2'b10);

   // R7: a stalled result stays valid and unchanged
   a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R7: a stalled last stage waits in the halt code
   a_r7_halt_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> stage_st[5:4] == 2'b11);

   // R9: an unloading stage hands over to a loading neighbour in one edge
   a_r9_handover: assert property (@(posedge clk) disable iff (!rst_n)
      stage_st[1:0] == 2'b10 && stage_st[3:2] == 2'b00
      |=> stage_st[1:0] == 2'b00 && stage_st[3:2] == 2'b01);
endmodule

bind fft8_engine fft8_engine_chk #(.DW(DATA_W)) u_chk (.*);

// File: tb/sim_fft8_engine.sv
module sim_fft8_engine;
   localparam int DW = 18;
   localparam int LW = 2 * DW;
   localparam int N  = 8;

   typedef struct packed {
      logic [3:0]      req;
      logic            exact;
      logic [N*LW-1:0] v;
   } exp_t;

   exp_t exp_q[$];

   logic clk = 1'b0, rst_n = 1'b0, inverse = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
   logic [N*LW-1:0] in_data = '0;
   logic in_ready, out_valid;
   logic [N*LW-1:0] out_data;
   logic [5:0] stage_st;

   int checks = 0, fails = 0, cyc = 0, acc_cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   fft8_engine u0 (
      .clk(clk), .rst_n(rst_n), .inverse(inverse),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .stage_st(stage_st)
   );

   task automatic ck(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   // driver: builds the ideal spectrum, drives the row, queues it on acceptance
   task automatic send(input int xr[N], input int xi[N], input bit inv, input int req);
      exp_t e;
      real sr, si, c, s, ang;
      e.req   = 4'(req);
      e.exact = 1'b1;
      for (int n = 1; n < N; n += 2)
         if (xr[n] != 0 || xi[n] != 0) e.exact = 1'b0;
      for (int k = 0; k < N; k++) begin
         sr = 0.0;
         si = 0.0;
         for (int n = 0; n < N; n++) begin
            ang = 2.0 * 3.14159265358979324 * real'(n * k) / 8.0;
            c = $cos(ang);
            s = $sin(ang);
            if (inv) begin
               sr += real'(xr[n]) * c - real'(xi[n]) * s;
               si += real'(xi[n]) * c + real'(xr[n]) * s;
            end else begin
               sr += real'(xr[n]) * c + real'(xi[n]) * s;
               si += real'(xi[n]) * c - real'(xr[n]) * s;
            end
         end
         e.v[k*LW+DW +: DW] = DW'(int'(sr));
         e.v[k*LW +: DW]    = DW'(int'(si));
      end
      @(posedge clk);
      #1;
      for (int n = 0; n < N; n++) begin
         in_data[n*LW+DW +: DW] = DW'(xr[n]);
         in_data[n*LW +: DW]    = DW'(xi[n]);
      end
      inverse  = inv;
      in_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (in_ready) break;
      end
      @(posedge clk);
      #1;
      acc_cyc  = cyc;
      in_valid = 1'b0;
      inverse  = ~inv;   // R3: later changes of the mode must not reach this row
      exp_q.push_back(e);
   endtask

   task automatic rnd_row(output int xr[N], output int xi[N], input bit odd_zero);
      for (int n = 0; n < N; n++) begin
         xr[n] = int'($urandom_range(2047)) - 1024;
         xi[n] = int'($urandom_range(2047)) - 1024;
         if (odd_zero && (n % 2 == 1)) begin
            xr[n] = 0;
            xi[n] = 0;
         end
      end
   endtask

   // monitor: compares each transferred row with the oldest expected one
   always @(negedge clk) begin
      exp_t e;
      bit ok;
      int tol;
      logic [DW-1:0] d;
      if (rst_n && out_valid && out_ready) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R1: unexpected row, actual %h expected none", out_data);
         end else begin
            e   = exp_q.pop_front();
            tol = e.exact ? 0 : 1;
            ok  = 1'b1;
            for (int p = 0; p < 2 * N; p++) begin
               d = out_data[p*DW +: DW] - e.v[p*DW +: DW];
               if (int'($signed(d)) > tol || int'($signed(d)) < -tol) ok = 1'b0;
            end
            if (!ok) begin
               fails++;
               $display("FAIL R%0d: row actual %h expected %h (tolerance %0d)",
                        e.req, out_data, e.v, tol);
            end
         end
      end
   end

   initial begin
      int xr[N], xi[N];
      int prev;
      logic [N*LW-1:0] snap;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R5: reset state
      ck(in_ready == 1'b1, "R5 in_ready", int'(in_ready), 1);
      ck(out_valid == 1'b0, "R5 out_valid", int'(out_valid), 0);
      ck(stage_st == 6'b000000, "R5 stage_st", int'(stage_st), 0);

      // R6 and R8: state walk and latency on an empty pipeline (impulse, R4 exact)
      for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
      xr[0] = 5;
      send(xr, xi, 1'b0, 4);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         ck(stage_st == 6'(((i % 2) + 1) << (2 * (i / 2))), "R6 state walk",
            int'(stage_st), ((i % 2) + 1) << (2 * (i / 2)));
         ck(out_valid == (i == 5), "R8 latency", int'(out_valid), int'(i == 5));
      end

      // R1: forward, impulse on lane 1 then mixed rows
      for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
      xr[1] = 300; xi[1] = -77;
      send(xr, xi, 1'b0, 1);
      for (int r = 0; r < 6; r++) begin
         rnd_row(xr, xi, 1'b0);
         send(xr, xi, 1'b0, 1);
      end

      // R2: inverse rows
      for (int n = 0; n < N; n++) begin xr[n] = 0; xi[n] = 0; end
      xr[3] = -450; xi[3] = 211;
      send(xr, xi, 1'b1, 2);
      for (int r = 0; r < 6; r++) begin
         rnd_row(xr, xi, 1'b0);
         send(xr, xi, 1'b1, 2);
      end

      // R4: even-only rows are exact in both modes
      for (int r = 0; r < 4; r++) begin
         rnd_row(xr, xi, 1'b1);
         send(xr, xi, r[0], 4);
      end

      // R10: full-scale patterns
      for (int n = 0; n < N; n++) begin xr[n] = 1023; xi[n] = -1024; end
      send(xr, xi, 1'b0, 10);
      send(xr, xi, 1'b1, 10);
      for (int n = 0; n < N; n++) begin
         xr[n] = (n % 2 == 0) ? 1023 : -1024;
         xi[n] = (n % 2 == 0) ? -1024 : 1023;
      end
      send(xr, xi, 1'b0, 10);
      send(xr, xi, 1'b1, 10);
      while (exp_q.size() != 0) @(negedge clk);

      // R7: stalled output holds
      out_ready = 1'b0;
      rnd_row(xr, xi, 1'b0);
      send(xr, xi, 1'b0, 7);
      repeat (8) @(negedge clk);
      ck(out_valid == 1'b1, "R7 valid held", int'(out_valid), 1);
      ck(stage_st[5:4] == 2'b11, "R7 halt code", int'(stage_st[5:4]), 3);
      snap = out_data;
      repeat (4) @(negedge clk);
      ck(out_data == snap, "R7 data held", int'(out_data[31:0]), int'(snap[31:0]));
      @(posedge clk);
      #1 out_ready = 1'b1;
      while (exp_q.size() != 0) @(negedge clk);

      // R9 and R3: blocked output fills three stages with rows of mixed mode
      @(posedge clk);
      #1 out_ready = 1'b0;
      for (int r = 0; r < 3; r++) begin
         rnd_row(xr, xi, 1'b0);
         send(xr, xi, (r == 1), 3);
      end
      repeat (6) @(negedge clk);
      ck(in_ready == 1'b0, "R9 full in_ready", int'(in_ready), 0);
      ck(stage_st == 6'b111111, "R9 all halted", int'(stage_st), 63);
      ck(exp_q.size() == 3, "R9 rows in flight", exp_q.size(), 3);
      @(posedge clk);
      #1 out_ready = 1'b1;
      while (exp_q.size() != 0) @(negedge clk);

      // R9: one row every third cycle with the output free
      rnd_row(xr, xi, 1'b0);
      send(xr, xi, 1'b0, 1);
      prev = acc_cyc;
      for (int r = 0; r < 4; r++) begin
         rnd_row(xr, xi, 1'b0);
         send(xr, xi, r[0], 9);
         ck(acc_cyc - prev == 3, "R9 accept period", acc_cyc - prev, 3);
         prev = acc_cyc;
      end
      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule